// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Assignable Prescaler

This block is the general-purpose timer of a small microcontroller. An 8-bit count register advances from one of two sources. The first source is the core clock divided by two. The second is an edge on an external input pin, and software chooses whether rising or falling edges count. A programmable prescaler can be placed between the source and the counter, or bypassed. When it is in use, it divides the source rate by a power of two from 2 to 256.

Software sets the configuration through static option inputs: the source select, the edge polarity, the prescaler bypass and a 3-bit ratio code. Software can load the counter at any time through a write strobe and data byte, and the current count is always visible. When the count wraps from FFh to 00h, the block raises a single-cycle overflow pulse for the interrupt controller.

Top module: `tc_timer8`

## Requirements
- R1: After reset the count reads 00h and the overflow pulse is low.
- R2: With the internal source selected (`src_ext`=0) and the prescaler bypassed (`psc_off`=1), the count increases by one every second clock. The first increment lands on the second clock edge after reset or after a write.
- R3: With `psc_off`=0, ratio code n (0..7) divides the source ticks by 2^(n+1). With the internal source, the count therefore advances once every 2^(n+2) clocks. For example, n=0 gives every 4 clocks and n=7 gives every 512 clocks.
- R4: With `src_ext`=1, the pin passes through two synchronizing flip-flops before edge detection. A qualifying pin change moves the count on the third clock edge after it. In this mode the internal clock alone never changes the count.
- R5: `edge_fall`=0 counts rising pin edges only. `edge_fall`=1 counts falling pin edges only.
- R6: An increment from FFh gives 00h. In the same cycle that the count first reads 00h, `ovf` is high for exactly one clock.
- R7: A write (`wr_en`=1) loads `wr_data` on that clock edge. It takes priority over a coincident increment and raises no overflow.
- R8: A write also clears the prescaler and the half-rate phase, so the next increment is a full prescale period after the write.
- R9: With `psc_off`=1 the ratio code has no effect on the count rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External count pin, asynchronous |
| src_ext | input | 1 | 1 = count pin edges, 0 = count half-rate clock |
| edge_fall | input | 1 | 1 = falling pin edges, 0 = rising |
| psc_off | input | 1 | 1 = bypass prescaler |
| ratio | input | 3 | Prescale code n, divide by 2^(n+1) |
| wr_en | input | 1 | Counter write strobe |
| wr_data | input | 8 | Counter write value |
| count | output | 8 | Current count |
| ovf | output | 1 | One-clock pulse on wrap to 00h |

## Verification
The bench measures the counting rate in three configurations: bypassed, smallest ratio and largest ratio. Together these separate a missing half-rate stage, an off-by-one power in the ratio decode and a bypass that still divides. For the external source, the bench drives single pulses under each polarity setting. This shows whether the edge polarity is honoured and whether the synchronizer latency is exactly three edges. A load just before FFh exposes the wrap and the timing of the pulse. A reload partway through a prescale period tells a cleared prescaler apart from one that keeps its partial count.

// File: rtl/tc_pkg.sv
package tc_pkg;
   localparam int TC_CNT_W   = 8;
   localparam int TC_RATIO_W = 3;
   localparam int TC_SYNC    = 2;

   typedef struct packed {
      logic                  src_ext;
      logic                  edge_fall;
      logic                  psc_off;
      logic [TC_RATIO_W-1:0] ratio;
   } tc_cfg_t;
endpackage

// File: rtl/tc_source.sv
module tc_source #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic pin_i,
   input  logic sel_ext,
   input  logic edge_fall,
   output logic tick_o
);
   localparam int TOP = SYNC_STAGES;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tc_source: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] sh;
   logic         phase;
   logic         rise, fall;

   genvar g;
   generate
      for (g = 0; g <= TOP; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[g] <= 1'b0;
               else        sh[g] <= pin_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[g] <= 1'b0;
               else        sh[g] <= sh[g-1];
         end
      end
   endgenerate

   assign rise = sh[TOP-1] & ~sh[TOP];
   assign fall = ~sh[TOP-1] & sh[TOP];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   phase <= 1'b0;
      else if (clr) phase <= 1'b0;
      else          phase <= ~phase;

   assign tick_o = sel_ext ? (edge_fall ? fall : rise) : phase;

   logic [3:0] age;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        age <= '0;
      else if (age != 4'hF) age <= age + 4'd1;

   // R4: a detected rise reflects the pin SYNC_STAGES clocks earlier
   assert_sync_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && age > 4'(TOP + 1)) |-> ($past(pin_i, TOP) && !$past(pin_i, TOP + 1)));

   // R2: internal source never ticks on two consecutive clocks
   assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ext && tick_o && age > 4'd0) |=> (!tick_o || sel_ext));

   // R5: polarity select never lets both edges through
   assert_edge_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ext && tick_o) |-> (edge_fall ? !sh[TOP-1] : sh[TOP-1]));
endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               bypass,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               tick_i,
   output logic               tick_o
);
   localparam int PSC_W = 1 << RATIO_W;

   generate
      if (RATIO_W < 1 || RATIO_W > 5) begin : g_bad_ratio
         $error("tc_prescaler: RATIO_W out of range 1..5");
      end
   endgenerate

   logic [PSC_W-1:0] psc;
   logic [PSC_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < PSC_W; i++)
         mask[i] = (i <= int'(ratio));
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      psc <= '0;
      else if (clr)    psc <= '0;
      else if (tick_i) psc <= psc + 1'b1;

   assign tick_o = bypass ? tick_i : (tick_i && ((psc & mask) == mask));

   // R3: divided output only ever fires on a source tick
   assert_psc_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> tick_i);

   // R8: prescaler state is zero right after a clear
   assert_psc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (psc == '0));
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_q
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tc_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         if (wr_en)
            cnt_q <= wr_data;
         else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
            ovf_q <= (cnt_q == {CNT_W{1'b1}});
         end
      end

   logic seen;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;

   assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && seen) |-> (cnt_q == '0 && $past(cnt_q) == {CNT_W{1'b1}}));

   assert_ovf_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> !ovf_q);

   assert_write_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(wr_en)) |-> (cnt_q == $past(wr_data) && !ovf_q));

   assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !$past(wr_en) && cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tc_timer8.sv
module tc_timer8
   import tc_pkg::*;
#(
   parameter int CNT_W       = TC_CNT_W,
   parameter int RATIO_W     = TC_RATIO_W,
   parameter int SYNC_STAGES = TC_SYNC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_i,
   input  logic               src_ext,
   input  logic               edge_fall,
   input  logic               psc_off,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               wr_en,
   input  logic [CNT_W-1:0]   wr_data,
   output logic [CNT_W-1:0]   count,
   output logic               ovf
);
   logic src_tick;
   logic cnt_inc;

   tc_source #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (wr_en),
      .pin_i     (pin_i),
      .sel_ext   (src_ext),
      .edge_fall (edge_fall),
      .tick_o    (src_tick)
   );

   tc_prescaler #(.RATIO_W(RATIO_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (wr_en),
      .bypass (psc_off),
      .ratio  (ratio),
      .tick_i (src_tick),
      .tick_o (cnt_inc)
   );

   tc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (cnt_inc),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cnt_q   (count),
      .ovf_q   (ovf)
   );

   // R9: in bypass every source tick reaches the counter
   assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      psc_off |-> (cnt_inc == src_tick));
endmodule

// File: tb/sim_tc_timer8.sv
`timescale 1ns/1ps
module sim_tc_timer8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_i = 1'b0;
   logic       src_ext = 1'b0;
   logic       edge_fall = 1'b0;
   logic       psc_off = 1'b1;
   logic [2:0] ratio = 3'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] count;
   logic       ovf;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   tc_timer8 u0 (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .src_ext(src_ext),
      .edge_fall(edge_fall), .psc_off(psc_off), .ratio(ratio),
      .wr_en(wr_en), .wr_data(wr_data), .count(count), .ovf(ovf)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 count", count, 8'h00);
      chk("R1 ovf", {7'd0, ovf}, 8'h00);
   endtask

   task automatic t_internal;
      src_ext = 0; psc_off = 1; ratio = 0;
      load(8'h10);
      edges(1);  chk("R2 before first", count, 8'h10);
      edges(1);  chk("R2 first", count, 8'h11);
      edges(18); chk("R2 ten steps", count, 8'h1A);
   endtask

   task automatic t_ratio;
      psc_off = 0; ratio = 3'd0;
      load(8'h40);
      edges(3); chk("R3 n0 hold", count, 8'h40);
      edges(1); chk("R3 n0 step", count, 8'h41);
      edges(4); chk("R3 n0 step2", count, 8'h42);
      ratio = 3'd7;
      load(8'h50);
      edges(511); chk("R3 n7 hold", count, 8'h50);
      edges(1);   chk("R3 n7 step", count, 8'h51);
   endtask

   task automatic t_bypass;
      psc_off = 1; ratio = 3'd7;
      load(8'h60);
      edges(2); chk("R9 ratio ignored", count, 8'h61);
      edges(8); chk("R9 ratio ignored 2", count, 8'h65);
   endtask

   task automatic t_overflow;
      psc_off = 1;
      load(8'hFE);
      edges(2); chk("R6 at FF", count, 8'hFF);
      chk("R6 no early pulse", {7'd0, ovf}, 8'h00);
      edges(2); chk("R6 wrap", count, 8'h00);
      chk("R6 pulse", {7'd0, ovf}, 8'h01);
      edges(1); chk("R6 pulse ends", {7'd0, ovf}, 8'h00);
   endtask

   task automatic t_write;
      psc_off = 1;
      load(8'hFE);
      edges(1);          // next edge would increment FF->00 region
      load(8'h33);       // write lands on an increment edge
      chk("R7 load wins", count, 8'h33);
      load(8'hFF);
      edges(1);
      load(8'h05);       // write on the edge that would have wrapped
      chk("R7 no wrap", count, 8'h05);
      chk("R7 no pulse", {7'd0, ovf}, 8'h00);
   endtask

   task automatic t_psc_clear;
      psc_off = 0; ratio = 3'd1;   // every 8 clocks
      load(8'h10);
      edges(6); chk("R8 mid period", count, 8'h10);
      load(8'h20);
      edges(6); chk("R8 after clear hold", count, 8'h20);
      edges(1); chk("R8 full period hold", count, 8'h20);
      edges(1); chk("R8 full period step", count, 8'h21);
   endtask

   task automatic t_external;
      src_ext = 1; edge_fall = 0; psc_off = 1; pin_i = 0;
      edges(4);
      load(8'h80);
      edges(20); chk("R4 clock ignored", count, 8'h80);
      pin_i = 1;
      edges(2); chk("R4 sync hold", count, 8'h80);
      edges(1); chk("R4 rise counted", count, 8'h81);
      pin_i = 0;
      edges(5); chk("R5 fall ignored in rising mode", count, 8'h81);
      edge_fall = 1;
      load(8'h90);
      pin_i = 1;
      edges(5); chk("R5 rise ignored in falling mode", count, 8'h90);
      pin_i = 0;
      edges(2); chk("R5 fall sync hold", count, 8'h90);
      edges(1); chk("R5 fall counted", count, 8'h91);
      src_ext = 0; edge_fall = 0;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      edges(3);
      rst_n = 1'b1;
      t_reset();
      t_internal();
      t_ratio();
      t_bypass();
      t_overflow();
      t_write();
      t_psc_clear();
      t_external();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule